// File: doc/BRIEF.md
# LED Matrix Column Scanner

This block refreshes a multiplexed LED matrix from a small on-chip pixel store. Time is cut into column slots of equal length. Each slot opens with a single blank cycle in which every column enable is off. During that cycle the scanner reads the pattern for the coming column out of the store. For the rest of the slot exactly one column enable is on, and the row lines carry that column's pattern. Columns are visited in ascending order and wrap around. The slot length is computed at elaboration from the clock frequency, the column count and the target frame rate, so a whole frame repeats at least as often as requested.

The pixel store has a single port that is shared over time. The scanner owns it in the blank cycle, and host writes may use it in every other cycle. The host presents a column address and a row pattern on a ready/valid port. An accepted write waits in a one-entry holding register until a cycle in which the port is free, so the host can change the picture while refresh carries on and no write is dropped.

Top module: `led_matrix_scan`

## Requirements
- R1: At most one bit of the column enable output is high in any cycle, and exactly one bit is high in every cycle of a slot except its first.
- R2: Each slot lasts SLOT = CLK_HZ / (COLS * REFRESH_HZ) cycles (integer division, at least 2): one blank cycle with all column enables low, then SLOT-1 cycles with a single column active.
- R3: After reset the first active column is column 0 (bit 0 of the enable output). Each later slot activates the column whose index is one higher, and column COLS-1 is followed by column 0.
- R4: While a column is active, the row output equals the pattern held for that column in the store at that slot's blank cycle, with bit i driving row i. During blank cycles the row output is all zeros.
- R5: Within one slot the column enables and the row output stay constant in every active cycle.
- R6: wr_ready_o is high exactly when the holding register is empty. A write is accepted on a clock edge where wr_valid_i and wr_ready_o are both high, and wr_ready_o is low in the cycle that follows. While wr_ready_o is low, wr_valid_i has no effect.
- R7: A held write reaches the store at the end of the first non-blank cycle it sees. A write that is pending during a blank cycle is held through that cycle, and wr_ready_o returns high two cycles after that blank cycle.
- R8: A write to the column that is currently shown, or to the column read in the blank cycle the write waits through, leaves the row output unchanged for the rest of that slot. The new pattern appears in that column's next slot.
- R9: During and right after reset all column enables and all row lines are low, and wr_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_valid_i | input | 1 | Host write request valid |
| wr_ready_o | output | 1 | Holding register empty, write can be taken |
| wr_col_i | input | $clog2(COLS) | Column index of the host write |
| wr_row_i | input | ROWS | Row pattern for that column |
| col_en_o | output | COLS | Column enables, active high |
| row_o | output | ROWS | Row pattern of the active column |

## Verification
The collision of interest is the scanner's read of the next column and the commit of a held host write, since both want the single store port. The bench raises a write in the last active cycle of a slot and aims it at the column about to be read. That write is therefore pending across the blank cycle. The bench then checks three things: wr_ready_o stays low through the blank cycle and the first active cycle; the newly shown column still shows its old pattern; and the new pattern appears exactly one frame later. A second case writes into the column on display, so that host writes and scanner output overlap within one slot.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    typedef enum logic {
        PH_BLANK = 1'b0,
        PH_SHOW  = 1'b1
    } scan_phase_e;

    // Cycles per column slot so that all columns repeat at least at rate_hz.
    function automatic int unsigned slot_len(input int unsigned clk_hz,
                                             input int unsigned cols,
                                             input int unsigned rate_hz);
        int unsigned n;
        n = clk_hz / (cols * rate_hz);
        if (n < 2) n = 2;
        return n;
    endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer
    import led_scan_pkg::*;
#(
    parameter int COLS = 8,
    parameter int SLOT = 4,
    localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int TICK_W = $clog2(SLOT)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic [COL_W-1:0] col_o,
    output scan_phase_e      phase_o
);
    logic [TICK_W-1:0] tick_q;
    logic [COL_W-1:0]  col_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tick_q <= '0;
            col_q  <= '0;
        end else if (tick_q == TICK_W'(SLOT - 1)) begin
            tick_q <= '0;
            col_q  <= (col_q == COL_W'(COLS - 1)) ? '0 : col_q + 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign col_o   = col_q;
    assign phase_o = (tick_q == '0) ? PH_BLANK : PH_SHOW;
endmodule

// File: rtl/wr_hold_reg.sv
module wr_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         in_valid_i,
    output logic         in_ready_o,
    input  logic [W-1:0] in_data_i,
    output logic         out_valid_o,
    output logic [W-1:0] out_data_o,
    input  logic         out_take_i
);
    logic         full_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (full_q && out_take_i) begin
            full_q <= 1'b0;
        end else if (in_valid_i && !full_q) begin
            full_q <= 1'b1;
            data_q <= in_data_i;
        end
    end

    assign in_ready_o  = !full_q;
    assign out_valid_o = full_q;
    assign out_data_o  = data_q;
endmodule

// File: rtl/pixel_store.sv
module pixel_store #(
    parameter int COLS = 8,
    parameter int ROWS = 8,
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rd_en_i,
    input  logic [COL_W-1:0] rd_col_i,
    output logic [ROWS-1:0]  rd_row_o,
    input  logic             wr_en_i,
    input  logic [COL_W-1:0] wr_col_i,
    input  logic [ROWS-1:0]  wr_row_i
);
    logic [ROWS-1:0] mem_q [COLS];
    logic [ROWS-1:0] rd_q;

    always_ff @(posedge clk_i) begin
        if (wr_en_i) mem_q[wr_col_i] <= wr_row_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)        rd_q <= '0;
        else if (rd_en_i) rd_q <= mem_q[rd_col_i];
    end

    assign rd_row_o = rd_q;
endmodule

// File: rtl/led_matrix_scan.sv
module led_matrix_scan
    import led_scan_pkg::*;
#(
    parameter int COLS       = 8,
    parameter int ROWS       = 8,
    parameter int CLK_HZ     = 1_000_000,
    parameter int REFRESH_HZ = 100,
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int SLOT  = slot_len(CLK_HZ, COLS, REFRESH_HZ),
    localparam int REQ_W = COL_W + ROWS
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_valid_i,
    output logic             wr_ready_o,
    input  logic [COL_W-1:0] wr_col_i,
    input  logic [ROWS-1:0]  wr_row_i,
    output logic [COLS-1:0]  col_en_o,
    output logic [ROWS-1:0]  row_o
);
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROWS-1:0]  row;
    } wr_req_t;

    logic [COL_W-1:0] scan_col;
    scan_phase_e      phase;
    wr_req_t          req_in, req_held;
    logic [REQ_W-1:0] held_bits;
    logic             held_valid;
    logic             port_write;
    logic [ROWS-1:0]  rd_row;

    scan_timer #(.COLS(COLS), .SLOT(SLOT)) timer_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .col_o  (scan_col),
        .phase_o(phase)
    );

    assign req_in = '{col: wr_col_i, row: wr_row_i};

    wr_hold_reg #(.W(REQ_W)) hold_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .in_valid_i (wr_valid_i),
        .in_ready_o (wr_ready_o),
        .in_data_i  (req_in),
        .out_valid_o(held_valid),
        .out_data_o (held_bits),
        .out_take_i (port_write)
    );

    assign req_held   = wr_req_t'(held_bits);
    // Store port: scanner owns the blank cycle, host owns the rest.
    assign port_write = held_valid && (phase == PH_SHOW);

    pixel_store #(.COLS(COLS), .ROWS(ROWS)) store_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .rd_en_i (phase == PH_BLANK),
        .rd_col_i(scan_col),
        .rd_row_o(rd_row),
        .wr_en_i (port_write),
        .wr_col_i(req_held.col),
        .wr_row_i(req_held.row)
    );

    for (genvar g = 0; g < COLS; g++) begin : g_col_dec
        assign col_en_o[g] = (phase == PH_SHOW) && (scan_col == COL_W'(g));
    end

    assign row_o = (phase == PH_SHOW) ? rd_row : '0;
endmodule

// File: rtl/led_matrix_scan_chk.sv
module led_matrix_scan_chk
    import led_scan_pkg::*;
#(
    parameter int COLS       = 8,
    parameter int ROWS       = 8,
    parameter int CLK_HZ     = 1_000_000,
    parameter int REFRESH_HZ = 100,
    localparam int SLOT  = slot_len(CLK_HZ, COLS, REFRESH_HZ),
    localparam int CNT_W = $clog2(SLOT) + 1
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            wr_valid_i,
    input logic            wr_ready_o,
    input logic [COLS-1:0] col_en_o,
    input logic [ROWS-1:0] row_o
);
    logic [CNT_W-1:0] act_cnt;
    logic [COLS-1:0]  last_col;
    logic             seen;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            act_cnt  <= '0;
            last_col <= '0;
            seen     <= 1'b0;
        end else if (col_en_o != '0) begin
            act_cnt  <= act_cnt + 1'b1;
            last_col <= col_en_o;
            seen     <= 1'b1;
        end else begin
            act_cnt  <= '0;
        end
    end

    assert_one_col_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(col_en_o));

    assert_slot_len_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (col_en_o == '0 && seen) |-> act_cnt == CNT_W'(SLOT - 1));

    assert_blank_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (col_en_o == '0 && seen) |=> col_en_o != '0);

    assert_first_col_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (col_en_o != '0 && !seen) |-> col_en_o == COLS'(1));

    assert_col_order_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (col_en_o != '0 && seen && act_cnt == '0) |->
            col_en_o == ((last_col << 1) | (last_col >> (COLS - 1))));

    assert_blank_rows_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (col_en_o == '0) |-> row_o == '0);

    assert_steady_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (col_en_o != '0 && act_cnt != '0) |-> ($stable(col_en_o) && $stable(row_o)));

    assert_accept_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_valid_i && wr_ready_o) |=> !wr_ready_o);

    assert_commit_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!wr_ready_o && col_en_o != '0) |=> wr_ready_o);

    assert_hold_blank_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!wr_ready_o && col_en_o == '0) |=> !wr_ready_o);
endmodule

bind led_matrix_scan led_matrix_scan_chk #(
    .COLS(COLS), .ROWS(ROWS), .CLK_HZ(CLK_HZ), .REFRESH_HZ(REFRESH_HZ)
) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_valid_i(wr_valid_i),
    .wr_ready_o(wr_ready_o),
    .col_en_o  (col_en_o),
    .row_o     (row_o)
);

// File: tb/led_matrix_scan_tb.sv
module led_matrix_scan_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int COLS = 4;
    localparam int ROWS = 8;
    localparam int CLK_HZ = 2400;
    localparam int REFRESH_HZ = 100;
    localparam int SLOT = 6;          // 2400 / (4 * 100)
    localparam int COL_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_valid = 1'b0;
    logic             wr_ready;
    logic [COL_W-1:0] wr_col = '0;
    logic [ROWS-1:0]  wr_row = '0;
    logic [COLS-1:0]  col_en;
    logic [ROWS-1:0]  row;

    int total = 0;
    int bad = 0;
    logic [ROWS-1:0] pat [COLS];

    always #(CLK_PERIOD / 2) clk = ~clk;

    led_matrix_scan #(
        .COLS(COLS), .ROWS(ROWS), .CLK_HZ(CLK_HZ), .REFRESH_HZ(REFRESH_HZ)
    ) dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .wr_valid_i(wr_valid),
        .wr_ready_o(wr_ready),
        .wr_col_i  (wr_col),
        .wr_row_i  (wr_row),
        .col_en_o  (col_en),
        .row_o     (row)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Call at a falling edge; returns one falling edge after acceptance.
    task automatic host_write(input int c, input logic [ROWS-1:0] d);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_col   = COL_W'(c);
        wr_row   = d;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(wr_ready == 1'b0, "R6", "ready after accept", 32'(wr_ready), 0);
    endtask

    // Returns at the falling edge of a blank cycle; nxt is the column to come.
    task automatic sync_blank(output int nxt);
        logic [COLS-1:0] last;
        last = '0;
        while (col_en == '0) @(negedge clk);
        while (col_en != '0) begin
            last = col_en;
            @(negedge clk);
        end
        nxt = 0;
        for (int i = 0; i < COLS; i++) if (last[i]) nxt = (i + 1) % COLS;
    endtask

    // Starts at a blank falling edge, ends at the next blank falling edge.
    task automatic check_slot(input int c, input logic [ROWS-1:0] p);
        for (int i = 1; i < SLOT; i++) begin
            @(negedge clk);
            chk(col_en == COLS'(1 << c), "R1", "column enable", 32'(col_en), 32'(1 << c));
            chk(row == p, "R4", "row pattern", 32'(row), 32'(p));
        end
        @(negedge clk);
        chk(col_en == '0, "R2", "blank after slot", 32'(col_en), 0);
        chk(row == '0, "R4", "blank rows", 32'(row), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(col_en == '0, "R9", "col_en in reset", 32'(col_en), 0);
        chk(row == '0, "R9", "row in reset", 32'(row), 0);
        chk(wr_ready == 1'b1, "R9", "ready in reset", 32'(wr_ready), 1);
        rst = 1'b0;
        chk(col_en == '0, "R9", "col_en after reset", 32'(col_en), 0);
        @(negedge clk);
        chk(col_en == COLS'(1), "R3", "first column", 32'(col_en), 1);
    endtask

    task automatic t_fill();
        for (int c = 0; c < COLS; c++) begin
            pat[c] = ROWS'(8'h1B + 8'h35 * c);
            host_write(c, pat[c]);
        end
        repeat (2 * COLS * SLOT) @(negedge clk);
    endtask

    task automatic t_frame();
        int n;
        sync_blank(n);
        for (int k = 0; k < 2 * COLS; k++) check_slot((n + k) % COLS, pat[(n + k) % COLS]);
    endtask

    task automatic t_live_update();
        int n;
        logic [ROWS-1:0] old_p;
        sync_blank(n);
        old_p = pat[n];
        @(negedge clk);
        host_write(n, 8'hC3);
        for (int i = 2; i < SLOT; i++) begin
            chk(row == old_p, "R8", "shown row kept", 32'(row), 32'(old_p));
            @(negedge clk);
        end
        chk(col_en == '0, "R2", "blank after live slot", 32'(col_en), 0);
        pat[n] = 8'hC3;
        for (int k = 1; k < COLS; k++) check_slot((n + k) % COLS, pat[(n + k) % COLS]);
        check_slot(n, pat[n]);
    endtask

    task automatic t_collide();
        int n, t;
        logic [ROWS-1:0] old_p;
        sync_blank(n);
        t = (n + 1) % COLS;
        old_p = pat[t];
        repeat (SLOT - 1) @(negedge clk);
        chk(wr_ready == 1'b1, "R6", "ready before collide", 32'(wr_ready), 1);
        wr_valid = 1'b1;
        wr_col   = COL_W'(t);
        wr_row   = 8'h5A;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(col_en == '0, "R2", "collide blank", 32'(col_en), 0);
        chk(wr_ready == 1'b0, "R7", "held in blank", 32'(wr_ready), 0);
        @(negedge clk);
        chk(wr_ready == 1'b0, "R7", "held first active", 32'(wr_ready), 0);
        chk(row == old_p, "R8", "read got old", 32'(row), 32'(old_p));
        @(negedge clk);
        chk(wr_ready == 1'b1, "R7", "committed", 32'(wr_ready), 1);
        chk(row == old_p, "R8", "row kept after commit", 32'(row), 32'(old_p));
        for (int i = 3; i < SLOT; i++) @(negedge clk);
        @(negedge clk);
        pat[t] = 8'h5A;
        for (int k = 0; k < COLS; k++) check_slot((t + 1 + k) % COLS, pat[(t + 1 + k) % COLS]);
    endtask

    task automatic t_back_to_back();
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_col   = COL_W'(0);
        wr_row   = 8'h81;
        @(negedge clk);
        chk(wr_ready == 1'b0, "R6", "ready low after first", 32'(wr_ready), 0);
        wr_col = COL_W'(3);
        wr_row = 8'h7E;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        chk(wr_ready == 1'b0, "R6", "ready low after second", 32'(wr_ready), 0);
        pat[0] = 8'h81;
        pat[3] = 8'h7E;
        repeat (2 * COLS * SLOT) @(negedge clk);
        t_frame();
    endtask

    initial begin
        t_reset();
        t_fill();
        t_frame();
        t_live_update();
        t_collide();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule